// File: doc/BRIEF.md
# I2C Target with Event Flags

This block is a 7-bit-address I2C target. It connects to open-drain SCL and SDA lines. SCL is only sampled. For SDA, the block samples the line and has one pull-low enable. Local software configures the block through a small register port. Software sets the own address, enables the interface, allows general-call response and can force a negative acknowledge on received bytes.

Every bus event sets its own flag in a status register: address match, general call, transfer direction, byte received, byte transmitted, transmit buffer empty and STOP. Software clears one flag by writing 0 to that bit and 1 to every other bit. An interrupt enable register has the same bit layout as the status register. The interrupt output is high when any flag is set whose enable bit is also set.

The bus inputs pass through a synchronizer before START, STOP and SCL edges are detected. The target never stretches SCL. In read mode, software must therefore have the next byte in the data port before that byte starts on the bus.

Top module: `i2c_target_evt`

## Requirements
- R1: After reset, every register reads 0, SDA is not pulled low and the interrupt output is low. The register indices are: 0 control, 1 own address, 2 status, 3 interrupt enable, 4 data port.
- R2: The target compares bits 7:1 of the first byte after a START with the own address (index 1, bits 6:0). On a match it pulls SDA low for the acknowledge bit. It sets status bit 0 (address received) and writes the byte's bit 0 into status bit 5 (transmit mode, 1 = controller reads).
- R3: After a non-matching address, the target gives no acknowledge and sets no flag. It ignores every later byte until the next START, even a byte that carries its own address.
- R4: With control bit 1 (general-call enable) set, address 0 is acknowledged and sets status bits 6 and 0. With control bit 1 clear, address 0 is not acknowledged and sets no flag.
- R5: In a write, each received byte appears on the data port and sets status bit 1. The byte is acknowledged when control bit 0 (forced NACK) is clear and not acknowledged when that bit is set.
- R6: In a read, the target loads the data port into its shifter when the address acknowledge ends and after every byte the controller acknowledges. It sends the byte MSB first. Each load sets status bit 3 (data empty). Status bit 2 (data transmitted) is set when the acknowledge bit that follows each byte is sampled.
- R7: If the controller does not acknowledge a byte the target sent, the read ends. The target releases SDA and reads back as all ones until the next START or STOP.
- R8: A STOP sets status bit 4 only if the target was addressed since the previous STOP.
- R9: A write to the status register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R10: The interrupt output is high exactly when a status bit is set whose bit in the interrupt enable register (index 3) is also set.
- R11: With control bit 2 (interface enable) clear, the target ignores the bus and never pulls SDA low.
- R12: The target starts pulling SDA low only in a cycle that follows SCL being seen low.
- R13: A repeated START makes the target compare the address again, even after an earlier mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| reg_addr_i | input | 3 | Register index |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the index on reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The address stage is tried with four patterns: the own address, a foreign address followed by the own address inside the same transfer, address 0 with general call enabled and disabled, and a repeated START after a mismatch. Together these separate matching from simply sampling the first byte on the bus. Write transfers run with forced NACK off and then on, which shows that the acknowledge follows the control bit and not the received data. Read transfers use a controller ACK followed by a NACK and then one extra byte. This shows that each buffer load takes the current port contents and that the target really lets go of SDA after the NACK. An interrupt reference model runs next to the design and is compared on every clock with all flags enabled and with a partial enable mask.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ST_W   = 7;
  localparam int unsigned CTL_W  = 4;

  localparam logic [REG_AW-1:0] REG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] REG_OWN  = 3'd1;
  localparam logic [REG_AW-1:0] REG_STAT = 3'd2;
  localparam logic [REG_AW-1:0] REG_IEN  = 3'd3;
  localparam logic [REG_AW-1:0] REG_DATA = 3'd4;

  localparam int unsigned C_FNACK = 0;
  localparam int unsigned C_GCEN  = 1;
  localparam int unsigned C_EN    = 2;
  localparam int unsigned C_BSEL  = 3;

  localparam int unsigned F_ADDR  = 0;
  localparam int unsigned F_RXD   = 1;
  localparam int unsigned F_TXD   = 2;
  localparam int unsigned F_EMPTY = 3;
  localparam int unsigned F_STOP  = 4;
  localparam int unsigned F_TXM   = 5;
  localparam int unsigned F_GC    = 6;

  typedef struct packed {
    logic              addr_hit;
    logic              rw;
    logic              gc;
    logic              rx_hit;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load;
    logic              tx_done;
    logic              stop_hit;
  } bus_ev_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2ct_bus_fsm.sv
module i2ct_bus_fsm
  import i2ct_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              gc_en_i,
  input  logic              fnack_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output bus_ev_t           ev_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    B_IDLE, B_ADDR, B_AACK, B_RX, B_RACK, B_TX, B_TACK, B_WAIT
  } bstate_e;

  bstate_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              ph_q, ph_d;
  logic              rw_q, rw_d;
  logic              hit_q, hit_d;
  logic              scl_q, sda_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] byte_in;
  logic own_match, gc_match;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign byte_in   = {sh_q[BYTE_W-2:0], sda_i};
  assign own_match = (byte_in[BYTE_W-1:1] == own_addr_i) && (byte_in[BYTE_W-1:1] != '0);
  assign gc_match  = gc_en_i && (byte_in[BYTE_W-1:1] == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    oe_d  = oe_q;
    ph_d  = ph_q;
    rw_d  = rw_q;
    hit_d = hit_q;
    ev_o  = '0;
    if (!en_i) begin
      st_d  = B_IDLE;
      oe_d  = 1'b0;
      hit_d = 1'b0;
    end else if (stop_det) begin
      ev_o.stop_hit = hit_q;
      hit_d = 1'b0;
      st_d  = B_IDLE;
      oe_d  = 1'b0;
    end else if (start_det) begin
      st_d  = B_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        B_ADDR: if (scl_rise) begin
          sh_d  = byte_in;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            if (own_match || gc_match) begin
              ev_o.addr_hit = 1'b1;
              ev_o.rw       = byte_in[0];
              ev_o.gc       = gc_match;
              rw_d  = byte_in[0];
              hit_d = 1'b1;
              ph_d  = 1'b0;
              st_d  = B_AACK;
            end else begin
              st_d = B_WAIT;
            end
          end
        end
        B_AACK: if (scl_fall) begin
          if (!ph_q) begin
            oe_d = 1'b1;
            ph_d = 1'b1;
          end else begin
            ph_d  = 1'b0;
            cnt_d = '0;
            if (rw_q) begin
              sh_d = tx_byte_i;
              oe_d = ~tx_byte_i[BYTE_W-1];
              ev_o.tx_load = 1'b1;
              st_d = B_TX;
            end else begin
              oe_d = 1'b0;
              st_d = B_RX;
            end
          end
        end
        B_RX: if (scl_rise) begin
          sh_d  = byte_in;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            ev_o.rx_hit  = 1'b1;
            ev_o.rx_byte = byte_in;
            ph_d = 1'b0;
            st_d = B_RACK;
          end
        end
        B_RACK: if (scl_fall) begin
          if (!ph_q) begin
            oe_d = ~fnack_i;
            ph_d = 1'b1;
          end else begin
            oe_d  = 1'b0;
            ph_d  = 1'b0;
            cnt_d = '0;
            st_d  = B_RX;
          end
        end
        B_TX: if (scl_fall) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            oe_d = 1'b0;
            ph_d = 1'b0;
            st_d = B_TACK;
          end else begin
            sh_d = {sh_q[BYTE_W-2:0], 1'b0};
            oe_d = ~sh_q[BYTE_W-2];
          end
        end
        B_TACK: begin
          if (scl_rise && !ph_q) begin
            ev_o.tx_done = 1'b1;
            ph_d = 1'b1;
            if (sda_i) st_d = B_WAIT;
          end else if (scl_fall && ph_q) begin
            ph_d  = 1'b0;
            cnt_d = '0;
            sh_d  = tx_byte_i;
            oe_d  = ~tx_byte_i[BYTE_W-1];
            ev_o.tx_load = 1'b1;
            st_d  = B_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
      ph_q  <= 1'b0;
      rw_q  <= 1'b0;
      hit_q <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      oe_q  <= oe_d;
      ph_q  <= ph_d;
      rw_q  <= rw_d;
      hit_q <= hit_d;
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign sda_oe_o = oe_q;

  p_off_no_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !oe_q);
  p_drive_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !$past(scl_i));
  p_nack_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o.tx_done && sda_i) |=> !oe_q);
  p_single_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_o.addr_hit, ev_o.rx_hit, ev_o.tx_load, ev_o.tx_done, ev_o.stop_hit}));
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  bus_ev_t           ev_i,
  output logic              en_o,
  output logic              gc_en_o,
  output logic              fnack_o,
  output logic [ADDR_W-1:0] own_addr_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              irq_o
);
  logic [CTL_W-1:0]  ctrl_q;
  logic [ADDR_W-1:0] own_q;
  logic [ST_W-1:0]   st_q, ien_q, st_set, st_keep, st_next;
  logic [BYTE_W-1:0] data_q;

  always_comb begin
    st_set          = '0;
    st_set[F_ADDR]  = ev_i.addr_hit;
    st_set[F_GC]    = ev_i.addr_hit & ev_i.gc;
    st_set[F_RXD]   = ev_i.rx_hit;
    st_set[F_TXD]   = ev_i.tx_done;
    st_set[F_EMPTY] = ev_i.tx_load;
    st_set[F_STOP]  = ev_i.stop_hit;
    st_keep = (reg_we_i && reg_addr_i == REG_STAT) ? reg_wdata_i[ST_W-1:0] : '1;
    // bus events win over a same-cycle clear
    st_next = (st_q & st_keep) | st_set;
    if (ev_i.addr_hit) st_next[F_TXM] = ev_i.rw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      own_q  <= '0;
      st_q   <= '0;
      ien_q  <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_next;
      if (reg_we_i && reg_addr_i == REG_CTRL) ctrl_q <= reg_wdata_i[CTL_W-1:0];
      if (reg_we_i && reg_addr_i == REG_OWN)  own_q  <= reg_wdata_i[ADDR_W-1:0];
      if (reg_we_i && reg_addr_i == REG_IEN)  ien_q  <= reg_wdata_i[ST_W-1:0];
      if (ev_i.rx_hit)                              data_q <= ev_i.rx_byte;
      else if (reg_we_i && reg_addr_i == REG_DATA)  data_q <= reg_wdata_i;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o = BYTE_W'(ctrl_q);
      REG_OWN:  reg_rdata_o = BYTE_W'(own_q);
      REG_STAT: reg_rdata_o = BYTE_W'(st_q);
      REG_IEN:  reg_rdata_o = BYTE_W'(ien_q);
      REG_DATA: reg_rdata_o = data_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign en_o       = ctrl_q[C_EN];
  assign gc_en_o    = ctrl_q[C_GCEN];
  assign fnack_o    = ctrl_q[C_FNACK];
  assign own_addr_o = own_q;
  assign tx_byte_o  = data_q;
  assign irq_o      = |(st_q & ien_q);

  p_wzc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_STAT && st_set == '0 && !ev_i.addr_hit)
      |=> st_q == ($past(st_q) & $past(reg_wdata_i[ST_W-1:0])));
  p_addr_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.addr_hit |=> (st_q[F_ADDR] && st_q[F_TXM] == $past(ev_i.rw)));
  p_rx_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.rx_hit |=> (data_q == $past(ev_i.rx_byte) && st_q[F_RXD]));
  p_gc_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.addr_hit && ev_i.gc) |=> st_q[F_GC]);
endmodule

// File: rtl/i2c_target_evt.sv
module i2c_target_evt
  import i2ct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic              scl_s, sda_s;
  logic              en, gc_en, fnack;
  logic [ADDR_W-1:0] own_addr;
  logic [BYTE_W-1:0] tx_byte;
  bus_ev_t           ev;

  i2ct_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  i2ct_bus_fsm u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .gc_en_i    (gc_en),
    .fnack_i    (fnack),
    .own_addr_i (own_addr),
    .tx_byte_i  (tx_byte),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .sda_oe_o   (sda_oe_o),
    .ev_o       (ev)
  );

  i2ct_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .ev_i        (ev),
    .en_o        (en),
    .gc_en_o     (gc_en),
    .fnack_o     (fnack),
    .own_addr_o  (own_addr),
    .tx_byte_o   (tx_byte),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/i2c_target_evt_bench.sv
module i2c_target_evt_bench;
  localparam int Q = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_OWN = 3'd1, A_STAT = 3'd2, A_IEN = 3'd3, A_DATA = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line, irq;
  logic [2:0] ra = '0;
  logic we = 1'b0;
  logic [7:0] wd = '0, rd;
  assign sda_line = sda_m & ~sda_oe;

  i2c_target_evt u_i2c_target_evt (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .reg_addr_i(ra), .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit mon_on = 1'b0, oe_seen = 1'b0;
  logic [6:0] exp_st = '0, exp_ie = '0;
  int cyc = 0;

  // reference interrupt model, compared every clock when the bus is quiet (R10)
  always @(negedge clk) begin
    if (sda_oe) oe_seen = 1'b1;
    if (mon_on) begin
      checks++;
      if (irq !== |(exp_st & exp_ie)) begin
        fails++;
        $display("FAIL R10 irq actual %0b expected %0b", irq, |(exp_st & exp_ie));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog all requirements actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    mon_on = 1'b0;
    @(negedge clk); ra = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); ra = a; #1; d = rd;
  endtask

  task automatic st_expect(string req, logic [6:0] st);
    logic [7:0] v;
    exp_st = st;
    reg_rd(A_STAT, v);
    chk(req, v, {1'b0, st});
    mon_on = 1'b1;
  endtask

  task automatic st_write(logic [7:0] w, logic [6:0] st);
    reg_wr(A_STAT, w);
    exp_st = st;
    mon_on = 1'b1;
  endtask

  task automatic bus_start;
    mon_on = 1'b0;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    mon_on = 1'b0;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic b;
    mon_on = 1'b0;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack);
    logic b;
    mon_on = 1'b0;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~ack);
  endtask

  initial begin
    logic [7:0] v;
    logic ack;
    wq(5);
    rst_n = 1'b1;
    wq(2);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 sda released", sda_oe, 0);
    chk("R1 irq low", irq, 0);

    reg_wr(A_OWN, 8'h42);
    reg_wr(A_IEN, 8'h7F); exp_ie = 7'h7F;
    reg_wr(A_CTRL, 8'h0C);
    reg_rd(A_CTRL, v); chk("R1 control readback", v, 8'h0C);
    mon_on = 1'b1;

    // write transfer
    bus_start;
    send_byte(8'h84, ack); chk("R2 address ack", ack, 1);
    st_expect("R2 address flag, write mode", 7'h01);
    st_write(8'hFF, 7'h01);
    st_expect("R9 ones leave flags", 7'h01);
    st_write(8'hFE, 7'h00);
    st_expect("R9 zero clears flag", 7'h00);
    send_byte(8'hA5, ack); chk("R5 data ack", ack, 1);
    st_expect("R5 received flag", 7'h02);
    reg_rd(A_DATA, v); chk("R5 data port", v, 8'hA5);
    st_write(8'hFD, 7'h00);
    reg_wr(A_CTRL, 8'h0D);
    send_byte(8'h3C, ack); chk("R5 forced nack", ack, 0);
    reg_rd(A_DATA, v); chk("R5 data port nacked byte", v, 8'h3C);
    st_write(8'h00, 7'h00);
    reg_wr(A_CTRL, 8'h0C); mon_on = 1'b1;
    bus_stop;
    st_expect("R8 stop after addressed", 7'h10);
    st_write(8'h00, 7'h00);

    // mismatch, then repeated start
    bus_start;
    send_byte(8'hA0, ack); chk("R3 foreign address nack", ack, 0);
    st_expect("R3 no flag", 7'h00);
    send_byte(8'h84, ack); chk("R3 ignored until start", ack, 0);
    st_expect("R3 no flag later", 7'h00);
    bus_start;
    send_byte(8'h84, ack); chk("R13 repeated start ack", ack, 1);
    st_expect("R13 address flag", 7'h01);
    bus_stop;
    st_expect("R8 stop flag", 7'h11);
    st_write(8'h00, 7'h00);

    // read transfer
    reg_wr(A_DATA, 8'h96); mon_on = 1'b1;
    bus_start;
    send_byte(8'h85, ack); chk("R2 read address ack", ack, 1);
    st_expect("R6 addr, tx mode, empty", 7'h29);
    reg_wr(A_DATA, 8'h5B);
    st_write(8'h00, 7'h00);
    recv_byte(v, 1'b1); chk("R6 first byte", v, 8'h96);
    st_expect("R6 transmitted and empty", 7'h0C);
    st_write(8'h00, 7'h00);
    recv_byte(v, 1'b0); chk("R6 second byte", v, 8'h5B);
    st_expect("R7 no reload after nack", 7'h04);
    reg_wr(A_DATA, 8'h00); mon_on = 1'b1;
    recv_byte(v, 1'b0); chk("R7 sda released", v, 8'hFF);
    st_expect("R7 no flags after nack", 7'h04);
    bus_stop;
    st_expect("R8 stop after read", 7'h14);
    st_write(8'h00, 7'h00);

    // general call
    reg_wr(A_CTRL, 8'h0E); mon_on = 1'b1;
    bus_start;
    send_byte(8'h00, ack); chk("R4 general call ack", ack, 1);
    st_expect("R4 general call flags", 7'h41);
    bus_stop;
    st_write(8'h00, 7'h00);
    reg_wr(A_CTRL, 8'h0C); mon_on = 1'b1;
    bus_start;
    send_byte(8'h00, ack); chk("R4 general call disabled", ack, 0);
    st_expect("R4 no flags", 7'h00);
    bus_stop;
    st_expect("R8 stop not addressed", 7'h00);

    // partial interrupt mask
    reg_wr(A_IEN, 8'h02); exp_ie = 7'h02; mon_on = 1'b1;
    bus_start;
    send_byte(8'h84, ack);
    st_expect("R10 flag set", 7'h01);
    chk("R10 masked irq", irq, 0);
    reg_wr(A_IEN, 8'h01); exp_ie = 7'h01; mon_on = 1'b1;
    wq(1);
    chk("R10 enabled irq", irq, 1);
    bus_stop;
    st_write(8'h00, 7'h00);

    // interface disabled
    reg_wr(A_CTRL, 8'h08); mon_on = 1'b1;
    oe_seen = 1'b0;
    bus_start;
    send_byte(8'h84, ack); chk("R11 disabled nack", ack, 0);
    bus_stop;
    chk("R11 sda never driven", oe_seen, 0);
    st_expect("R11 no flags", 7'h00);

    wq(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule